// File: doc/BRIEF.md
# Serial Link Command Decoder

This block sits on the codec side of a frame-based serial audio link. The controller sends frames of 256 bit periods, MSB first, on a serial data line. A sync line rises on the first bit of each frame. The first slot is 16 bits wide and holds tag bits and a 2-bit codec selection field. Twelve 20-bit slots follow it. The block shifts each frame in on the rising edge of the bit clock. From the frame it pulls out a register command (a read request, or a write with address and data) and the left and right PCM samples.

Two active-low strap pins set the block's identity. With both straps left high the block acts as the primary codec. It then checks the address and data tag bits of the first slot, and only acts on frames whose selection field is 00. Any other strap value makes it a secondary codec with identity 1, 2 or 3. A secondary codec ignores the two command tag bits and accepts the command when the selection field equals its own identity. The decoded strobes go to a register file and to the converters.

Top module: `slink_cmd_rx`

## Requirements
- R1: While reset is held, and after reset until the first rising edge of sync, rd_req, wr_stb, pcm_l_stb and pcm_r_stb are all 0.
- R2: codec_id equals the bitwise inverse of id_n. The value 00 (id_n = 11) means primary.
- R3: A rising edge of sync marks frame bit 0, which is bit 15 of slot 0. Slot 0 holds frame bits 0-15, and slot k (k = 1..12) starts at frame bit 16+20(k-1). Read and write strobes are visible in the cycle after the clock edge that samples frame bit 55, the last bit of slot 2.
- R4: When primary, a frame with selection field (slot 0 bits 1:0) equal to 00, address tag (slot 0 bit 14) set and slot 1 bit 19 set gives a one-cycle rd_req.
- R5: When primary, a write (slot 1 bit 19 clear) gives wr_stb only when both the address tag and the data tag (slot 0 bit 13) are set in the same frame.
- R6: When primary, a frame whose selection field is not 00 gives no rd_req and no wr_stb, whatever its tag bits.
- R7: When secondary, a frame whose selection field equals codec_id gives rd_req or wr_stb according to slot 1 bit 19, whatever slot 0 bits 14 and 13 hold.
- R8: When secondary, a frame whose selection field differs from codec_id gives no rd_req and no wr_stb, even with both tags set.
- R9: With a strobe, reg_addr carries slot 1 bits 18:12. With wr_stb, wr_data carries slot 2 bits 19:4, and slot 2 bits 3:0 are ignored.
- R10: pcm_l_stb pulses after the last bit of slot 3 (frame bit 75) only if slot 0 bit 12 is set, and pcm_l then holds slot 3. pcm_r_stb does the same for slot 4 (frame bit 95) with slot 0 bit 11 and pcm_r.
- R11: Every strobe is one cycle wide, and no two strobes are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; data sampled on rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync | input | 1 | Frame sync; rising edge marks frame bit 0 |
| sdo | input | 1 | Serial frame data from controller, MSB first |
| id_n | input | 2 | Active-low identity straps |
| codec_id | output | 2 | Decoded identity (register 28h bits 15:14) |
| rd_req | output | 1 | One-cycle register read request |
| wr_stb | output | 1 | One-cycle register write strobe |
| reg_addr | output | 7 | Register address of the command |
| wr_data | output | 16 | Register write data |
| pcm_l_stb | output | 1 | Left sample valid pulse |
| pcm_l | output | 20 | Left DAC sample |
| pcm_r_stb | output | 1 | Right sample valid pulse |
| pcm_r | output | 20 | Right DAC sample |

## Verification
Each of the four straps is driven with random frames. Tags, the selection field and the read bit are random, so every mix of tag and selection shows up.

Directed frames cover four cases:
- A secondary frame with both tags clear but a matching selection field. A decoder that still checks the tags would drop it.
- A frame with both tags set but the wrong selection field. A decoder that checks only the tags would act on it.
- A primary write with only the address tag set. A decoder that does not require both tags in the same frame would write anyway.
- A nonzero slot 2 low nibble. A decoder with the data field shifted by one or more bits would report the wrong write data.

The bench records the frame bit at which each strobe appears, so an off-by-one slot boundary or an extra pipeline stage shows up as a wrong position.

// File: rtl/slink_cmd_rx.sv
module slink_cmd_rx #(
  parameter int S0_W   = 16,
  parameter int SLOT_W = 20
) (
  input  logic              bclk,
  input  logic              rst_n,
  input  logic              sync,
  input  logic              sdo,
  input  logic [1:0]        id_n,
  output logic [1:0]        codec_id,
  output logic              rd_req,
  output logic              wr_stb,
  output logic [6:0]        reg_addr,
  output logic [15:0]       wr_data,
  output logic              pcm_l_stb,
  output logic [SLOT_W-1:0] pcm_l,
  output logic              pcm_r_stb,
  output logic [SLOT_W-1:0] pcm_r
);
  localparam int FRAME_W = S0_W + 12 * SLOT_W;
  localparam int CW      = $clog2(FRAME_W);
  localparam logic [CW-1:0] END_S0 = CW'(S0_W - 1);
  localparam logic [CW-1:0] END_S1 = CW'(S0_W + SLOT_W - 1);
  localparam logic [CW-1:0] END_S2 = CW'(S0_W + 2 * SLOT_W - 1);
  localparam logic [CW-1:0] END_S3 = CW'(S0_W + 3 * SLOT_W - 1);
  localparam logic [CW-1:0] END_S4 = CW'(S0_W + 4 * SLOT_W - 1);

  logic              sync_d, run;
  logic [CW-1:0]     cnt;
  logic [SLOT_W-2:0] sh;
  logic              t_adr, t_dat, t_l, t_r;
  logic [1:0]        sel_f;
  logic [SLOT_W-1:0] cmd_w;

  wire              start   = sync & ~sync_d;
  wire [CW-1:0]     pos     = start ? '0 : cnt;
  wire              act     = start | run;
  wire [SLOT_W-1:0] word    = {sh, sdo};
  wire              primary = (codec_id == 2'b00);
  wire              sel     = (sel_f == codec_id);
  wire              adr_ok  = sel & (primary ? t_adr : 1'b1);
  wire              dat_ok  = sel & (primary ? t_dat : 1'b1);

  assign codec_id = ~id_n;

  always_ff @(posedge bclk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b0; run <= 1'b0; cnt <= '0; sh <= '0;
      t_adr <= 1'b0; t_dat <= 1'b0; t_l <= 1'b0; t_r <= 1'b0;
      sel_f <= 2'b00; cmd_w <= '0;
      rd_req <= 1'b0; wr_stb <= 1'b0; reg_addr <= '0; wr_data <= '0;
      pcm_l_stb <= 1'b0; pcm_r_stb <= 1'b0; pcm_l <= '0; pcm_r <= '0;
    end else begin
      sync_d    <= sync;
      sh        <= word[SLOT_W-2:0];
      cnt       <= (pos == CW'(FRAME_W - 1)) ? '0 : pos + 1'b1;
      run       <= act;
      rd_req    <= 1'b0;
      wr_stb    <= 1'b0;
      pcm_l_stb <= 1'b0;
      pcm_r_stb <= 1'b0;
      if (act) begin
        if (pos == END_S0) begin
          t_adr <= word[14];
          t_dat <= word[13];
          t_l   <= word[12];
          t_r   <= word[11];
          sel_f <= word[1:0];
        end
        if (pos == END_S1) cmd_w <= word;
        if (pos == END_S2 && adr_ok) begin
          reg_addr <= cmd_w[18:12];
          if (cmd_w[19]) rd_req <= 1'b1;
          else if (dat_ok) begin
            wr_stb  <= 1'b1;
            wr_data <= word[19:4];
          end
        end
        if (pos == END_S3 && t_l) begin
          pcm_l_stb <= 1'b1;
          pcm_l     <= word;
        end
        if (pos == END_S4 && t_r) begin
          pcm_r_stb <= 1'b1;
          pcm_r     <= word;
        end
      end
    end
  end
endmodule

// File: rtl/slink_cmd_rx_chk.sv
module slink_cmd_rx_chk (
  input logic bclk,
  input logic rst_n,
  input logic rd_req,
  input logic wr_stb,
  input logic pcm_l_stb,
  input logic pcm_r_stb
);
  // R11
  strobe_excl_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    $onehot0({rd_req, wr_stb, pcm_l_stb, pcm_r_stb}));
  // R11
  wr_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  // R4
  rd_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    rd_req |=> !rd_req);
  // R10
  pcm_l_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    pcm_l_stb |=> !pcm_l_stb && !pcm_r_stb);
  // R10
  pcm_r_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
    pcm_r_stb |=> !pcm_r_stb);
endmodule

bind slink_cmd_rx slink_cmd_rx_chk u_chk (
  .bclk(bclk), .rst_n(rst_n), .rd_req(rd_req), .wr_stb(wr_stb),
  .pcm_l_stb(pcm_l_stb), .pcm_r_stb(pcm_r_stb)
);

// File: tb/slink_cmd_rx_test.sv
`timescale 1ns/1ps
module slink_cmd_rx_test;
  logic bclk = 1'b0, rst_n = 1'b0, sync = 1'b0, sdo = 1'b0;
  logic [1:0]  id_n = 2'b11;
  logic [1:0]  codec_id;
  logic        rd_req, wr_stb, pcm_l_stb, pcm_r_stb;
  logic [6:0]  reg_addr;
  logic [15:0] wr_data;
  logic [19:0] pcm_l, pcm_r;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 bclk = ~bclk;

  slink_cmd_rx uut (.bclk(bclk), .rst_n(rst_n), .sync(sync), .sdo(sdo), .id_n(id_n),
    .codec_id(codec_id), .rd_req(rd_req), .wr_stb(wr_stb), .reg_addr(reg_addr),
    .wr_data(wr_data), .pcm_l_stb(pcm_l_stb), .pcm_l(pcm_l),
    .pcm_r_stb(pcm_r_stb), .pcm_r(pcm_r));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_sel(input [1:0] strap, input [1:0] cid, input bit tag);
    logic [1:0] me = ~strap;
    if (me == 2'b00) return (cid == 2'b00) && tag;
    return cid == me;
  endfunction

  task automatic run_frame(input bit t14, t13, t12, t11, input [1:0] cid, input bit rdb,
                           input [6:0] a, input [15:0] d, input [3:0] nib,
                           input [19:0] l, r);
    logic [255:0] f;
    int nrd = 0, nwr = 0, npl = 0, npr = 0;
    int prd = -1, pwr = -1, ppl = -1, ppr = -1;
    logic [6:0] ga = '0; logic [15:0] gd = '0; logic [19:0] gl = '0, gr = '0;
    bit ea, ed, erd, ewr;
    f[255:240] = {1'b1, t14, t13, t12, t11, 9'h000, cid};
    f[239:220] = {rdb, a, 12'h000};
    f[219:200] = {d, nib};
    f[199:180] = l;
    f[179:160] = r;
    for (int i = 0; i < 5; i++) f[i*32 +: 32] = $urandom;
    for (int p = 0; p < 256; p++) begin
      @(negedge bclk);
      if (rd_req)    begin nrd++; prd = p; ga = reg_addr; end
      if (wr_stb)    begin nwr++; pwr = p; ga = reg_addr; gd = wr_data; end
      if (pcm_l_stb) begin npl++; ppl = p; gl = pcm_l; end
      if (pcm_r_stb) begin npr++; ppr = p; gr = pcm_r; end
      if ((rd_req + wr_stb + pcm_l_stb + pcm_r_stb) > 1)
        check(0, "R11", rd_req + wr_stb + pcm_l_stb + pcm_r_stb, 1);
      sync = (p < 16);
      sdo  = f[255-p];
    end
    @(negedge bclk);
    ea  = exp_sel(id_n, cid, t14);
    ed  = exp_sel(id_n, cid, t13);
    erd = ea && rdb;
    ewr = ea && !rdb && ed;
    check(nrd == int'(erd), (id_n == 2'b11) ? "R4/R6" : "R7/R8", nrd, erd);
    check(nwr == int'(ewr), (id_n == 2'b11) ? "R5/R6" : "R7/R8", nwr, ewr);
    if (erd) begin
      check(prd == 56, "R3 read position", prd, 56);
      check(ga == a, "R9 read address", ga, a);
    end
    if (ewr) begin
      check(pwr == 56, "R3 write position", pwr, 56);
      check(ga == a, "R9 write address", ga, a);
      check(gd == d, "R9 write data", gd, d);
    end
    check(npl == int'(t12), "R10 left strobe", npl, t12);
    check(npr == int'(t11), "R10 right strobe", npr, t11);
    if (t12) check(ppl == 76 && gl == l, "R10 left", {ppl[7:0], gl}, {8'd76, l});
    if (t11) check(ppr == 96 && gr == r, "R10 right", {ppr[7:0], gr}, {8'd96, r});
  endtask

  task automatic rand_frame();
    run_frame($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
              $urandom_range(0,1), 2'($urandom_range(0,3)), $urandom_range(0,1),
              7'($urandom), 16'($urandom), 4'($urandom), 20'($urandom), 20'($urandom));
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1badc0de));
    repeat (3) @(negedge bclk);
    // R1 strobes low in reset
    check({rd_req, wr_stb, pcm_l_stb, pcm_r_stb} == 4'b0, "R1 reset", {rd_req, wr_stb, pcm_l_stb, pcm_r_stb}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge bclk);
      if ({rd_req, wr_stb, pcm_l_stb, pcm_r_stb} != 4'b0)
        check(0, "R1 idle before sync", {rd_req, wr_stb, pcm_l_stb, pcm_r_stb}, 0);
      sdo = 1'($urandom);
    end
    check(1, "R1 idle before sync", 0, 0);
    for (int s = 3; s >= 0; s--) begin
      id_n = 2'(s);
      @(negedge bclk);
      // R2
      check(codec_id == ~id_n, "R2 identity", codec_id, ~id_n);
      if (s == 3) begin
        run_frame(1, 1, 1, 1, 2'b00, 0, 7'h28, 16'hA5C3, 4'hF, 20'h12345, 20'hFEDCB); // R5 R9
        run_frame(1, 0, 0, 0, 2'b00, 0, 7'h02, 16'h1111, 4'h0, 20'h0, 20'h0);         // R5 no data tag
        run_frame(1, 1, 0, 1, 2'b01, 1, 7'h7F, 16'h0, 4'h0, 20'h0, 20'hABCDE);        // R6
        run_frame(1, 0, 1, 0, 2'b00, 1, 7'h7E, 16'h0, 4'h0, 20'h5A5A5, 20'h0);        // R4
      end else begin
        run_frame(0, 0, 1, 1, ~id_n, 0, 7'h55, 16'h8001, 4'h9, 20'hFFFFF, 20'h00001); // R7
        run_frame(0, 0, 0, 0, ~id_n, 1, 7'h01, 16'h0, 4'h0, 20'h0, 20'h0);            // R7 read
        run_frame(1, 1, 0, 0, ~id_n ^ 2'b11, 0, 7'h33, 16'h7777, 4'h1, 20'h0, 20'h0); // R8
        run_frame(1, 1, 0, 0, 2'b00, 1, 7'h10, 16'h0, 4'h0, 20'h0, 20'h0);            // R8
      end
      repeat (40) rand_frame();
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule